// File: doc/BRIEF.md
# Logical Immediate Bitmask Decoder

This block expands the 13-bit compact immediate carried by a 64-bit bitwise-logic instruction into the full 64-bit mask it stands for. It also flags encodings that are reserved. The encoding has three fields: a wide-element bit, a rotate field and a size/length field. From these the block picks an element width of 2, 4, 8, 16, 32 or 64 bits. It fills the element with a run of ones that starts at bit 0, rotates the element right and copies it across the whole word.

No encoding can produce all zeros or all ones. Field combinations that would produce either value, and combinations that name no legal element width, are reported as invalid, and the mask is forced to zero. The result is registered, so it appears one clock after the input is presented. Decode logic feeds this block, and the execute stage reads its registered output.

Top module: `lid_decoder`

## Requirements
- R1: The element width is 2^k, where k is the index of the highest set bit in the 7-bit value {wide_i, ~size_i}. When wide_i=1 the element width is 64.
- R2: Inside the element, bits 0 through s are ones and all higher bits are zeros. Here s is size_i masked to the low k bits.
- R3: The element is rotated right by rot_i masked to its low k bits. Higher bits of rot_i have no effect on the result.
- R4: The rotated element is repeated 64/2^k times to fill the 64-bit mask.
- R5: If {wide_i, ~size_i} has no set bit, or its only set bit is bit 0 (a 1-bit element), the encoding is reported invalid.
- R6: If s equals 2^k-1, which would make the element all ones, the encoding is reported invalid.
- R7: While invalid_o is 1 the mask is zero. A valid result is never all zeros and never all ones.
- R8: vld_o is 1 exactly one cycle after in_vld_i was 1. The mask and invalid_o for that input appear in the same cycle.
- R9: In a cycle with in_vld_i=0, the registered mask and invalid_o keep their values.
- R10: While rst is high, vld_o, invalid_o and mask_o are zero.
- R11: A single set bit at every position, and a single clear bit at every position, can be encoded using wide_i=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld_i | input | 1 | Fields are presented this cycle |
| wide_i | input | 1 | Wide-element bit |
| rot_i | input | 6 | Right-rotate amount field |
| size_i | input | 6 | Element size / run length field |
| vld_o | output | 1 | Registered result is fresh |
| mask_o | output | 64 | Decoded 64-bit immediate |
| invalid_o | output | 1 | Encoding is reserved |

## Verification
The bench builds the block with its default parameters: a 64-bit word and 6-bit fields. With those values the whole encoding space has only 8192 points, so the bench applies every encoding and compares it against an index-based model that rotates after replication, not before. Hand-worked vectors pin down each element width, rotation that ignores the upper bits, and each reserved case. Sweeps of a single set bit and a single clear bit cover all 64 positions.

// File: rtl/lid_pkg.sv
package lid_pkg;
    localparam int unsigned IMM_W     = 64;
    localparam int unsigned FLD_W     = 6;
    localparam int unsigned LG_W      = $clog2(FLD_W + 1);
    localparam int unsigned NUM_SIZES = FLD_W;

    typedef struct packed {
        logic              reserved;
        logic [LG_W-1:0]   lg_size;
        logic [FLD_W-1:0]  len_m1;
        logic [FLD_W-1:0]  rot;
    } lid_fields_t;

    // level mask for an element of 2^lg bits, i.e. 2^lg - 1
    function automatic logic [FLD_W-1:0] lvl_mask(input logic [LG_W-1:0] lg);
        logic [FLD_W:0] full;
        full = (FLD_W+1)'(1) << lg;
        full = full - (FLD_W+1)'(1);
        return full[FLD_W-1:0];
    endfunction
endpackage

// File: rtl/lid_size_decode.sv
module lid_size_decode
    import lid_pkg::*;
(
    input  logic             wide_i,
    input  logic [FLD_W-1:0] rot_i,
    input  logic [FLD_W-1:0] size_i,
    output lid_fields_t      fields_o
);
    logic [FLD_W:0]   sel_vec;
    logic [LG_W-1:0]  hb;
    logic             found;
    logic [FLD_W-1:0] lvl;

    always_comb begin
        sel_vec = {wide_i, ~size_i};
        hb      = '0;
        found   = 1'b0;
        for (int b = 0; b <= FLD_W; b++) begin
            if (sel_vec[b]) begin
                hb    = LG_W'(b);
                found = 1'b1;
            end
        end
        lvl = lvl_mask(hb);
        fields_o.lg_size  = hb;
        fields_o.len_m1   = size_i & lvl;
        fields_o.rot      = rot_i & lvl;
        fields_o.reserved = !found || (hb == '0) || ((size_i & lvl) == lvl);
    end

    always_comb begin
        if (wide_i) begin
            assert (fields_o.lg_size == LG_W'(FLD_W)); // R1
        end
    end
endmodule

// File: rtl/lid_elem_build.sv
module lid_elem_build
    import lid_pkg::*;
(
    input  logic [LG_W-1:0]  lg_i,
    input  logic [FLD_W-1:0] len_m1_i,
    input  logic [FLD_W-1:0] rot_i,
    output logic [IMM_W-1:0] pattern_o
);
    logic [IMM_W-1:0] cand [NUM_SIZES];

    for (genvar k = 1; k <= NUM_SIZES; k++) begin : g_size
        localparam int unsigned ES = 1 << k;
        logic [k:0]    run_len;
        logic [ES-1:0] run;
        logic [ES-1:0] rotd;
        logic [k:0]    back;

        always_comb begin
            run_len = {1'b0, len_m1_i[k-1:0]} + (k+1)'(1);
            run     = ~({ES{1'b1}} << run_len);
            back    = (k+1)'(ES) - {1'b0, rot_i[k-1:0]};
            rotd    = (run >> rot_i[k-1:0]) | (run << back);
            cand[k-1] = {(IMM_W/ES){rotd}};
        end
    end

    always_comb begin
        pattern_o = '0;
        for (int s = 0; s < NUM_SIZES; s++) begin
            if (lg_i == LG_W'(s + 1)) pattern_o = cand[s];
        end
    end
endmodule

// File: rtl/lid_out_stage.sv
module lid_out_stage
    import lid_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld_i,
    input  logic             reserved_i,
    input  logic [IMM_W-1:0] pattern_i,
    output logic             vld_o,
    output logic [IMM_W-1:0] mask_o,
    output logic             invalid_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o     <= 1'b0;
            mask_o    <= '0;
            invalid_o <= 1'b0;
        end else begin
            vld_o <= in_vld_i;
            if (in_vld_i) begin
                invalid_o <= reserved_i;
                mask_o    <= reserved_i ? '0 : pattern_i;
            end
        end
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (vld_o == $past(in_vld_i))); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_vld_i)) |-> ($stable(mask_o) && $stable(invalid_o))); // R9
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
        invalid_o |-> (mask_o == '0)); // R7
    AST_NO_TRIVIAL: assert property (@(posedge clk) disable iff (rst)
        (vld_o && !invalid_o) |-> ((mask_o != '0) && (mask_o != '1))); // R7
endmodule

// File: rtl/lid_decoder.sv
module lid_decoder
    import lid_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld_i,
    input  logic             wide_i,
    input  logic [5:0]       rot_i,
    input  logic [5:0]       size_i,
    output logic             vld_o,
    output logic [63:0]      mask_o,
    output logic             invalid_o
);
    lid_fields_t      fields;
    logic [IMM_W-1:0] pattern;

    lid_size_decode u_size (
        .wide_i   (wide_i),
        .rot_i    (rot_i),
        .size_i   (size_i),
        .fields_o (fields)
    );

    lid_elem_build u_elem (
        .lg_i      (fields.lg_size),
        .len_m1_i  (fields.len_m1),
        .rot_i     (fields.rot),
        .pattern_o (pattern)
    );

    lid_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .in_vld_i   (in_vld_i),
        .reserved_i (fields.reserved),
        .pattern_i  (pattern),
        .vld_o      (vld_o),
        .mask_o     (mask_o),
        .invalid_o  (invalid_o)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!vld_o && !invalid_o && (mask_o == '0))); // R10
endmodule

// File: tb/lid_decoder_tb.sv
`timescale 1ns/1ps
module lid_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic        wide = 1'b0;
    logic [5:0]  rot = '0;
    logic [5:0]  size = '0;
    logic        vld;
    logic [63:0] mask;
    logic        inv;

    int applied = 0;
    int errors  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    lid_decoder u_dut (
        .clk(clk), .rst(rst), .in_vld_i(in_vld), .wide_i(wide),
        .rot_i(rot), .size_i(size), .vld_o(vld), .mask_o(mask), .invalid_o(inv)
    );

    // {wide, rot, size, expected mask, expected invalid}
    localparam int NV = 14;
    localparam logic [77:0] VEC [NV] = '{
        {1'b1, 6'd0,  6'd0,  64'h0000000000000001, 1'b0}, // R1 R2 64-bit, one bit
        {1'b1, 6'd1,  6'd0,  64'h8000000000000000, 1'b0}, // R3
        {1'b1, 6'd0,  6'd62, 64'h7FFFFFFFFFFFFFFF, 1'b0}, // R2
        {1'b1, 6'd63, 6'd62, 64'hFFFFFFFFFFFFFFFE, 1'b0}, // R3
        {1'b1, 6'd5,  6'd63, 64'h0,                1'b1}, // R6
        {1'b0, 6'd0,  6'b111100, 64'h5555555555555555, 1'b0}, // R4 2-bit
        {1'b0, 6'd1,  6'b111100, 64'hAAAAAAAAAAAAAAAA, 1'b0}, // R3 R4
        {1'b0, 6'd0,  6'b111101, 64'h0,            1'b1}, // R6
        {1'b0, 6'd3,  6'b111111, 64'h0,            1'b1}, // R5 no set bit
        {1'b0, 6'd0,  6'b111110, 64'h0,            1'b1}, // R5 1-bit element
        {1'b0, 6'd0,  6'b110011, 64'h0F0F0F0F0F0F0F0F, 1'b0}, // R1 8-bit
        {1'b0, 6'd4,  6'b110011, 64'hF0F0F0F0F0F0F0F0, 1'b0}, // R3
        {1'b0, 6'd8,  6'b000111, 64'hFF000000FF000000, 1'b0}, // R1 32-bit
        {1'b0, 6'b110001, 6'b100000, 64'h8000800080008000, 1'b0}  // R3 upper rot ignored
    };

    function automatic logic [64:0] ref_model(input logic w, input logic [5:0] r, input logic [5:0] s);
        logic [6:0]  cat;
        int          hb;
        int          es;
        int          sl;
        int          rl;
        logic [63:0] m;
        cat = {w, ~s};
        hb = -1;
        for (int b = 6; b >= 0; b--) if (cat[b] && hb < 0) hb = b;
        if (hb < 1) return {1'b1, 64'h0};
        es = 1 << hb;
        sl = int'(s) % es;
        rl = int'(r) % es;
        if (sl == es - 1) return {1'b1, 64'h0};
        m = '0;
        for (int i = 0; i < 64; i++) m[i] = (((i + rl) % es) <= sl);
        return {1'b0, m};
    endfunction

    task automatic check(input string req, input logic [63:0] em, input logic ei, input logic ev);
        applied++;
        if (mask !== em || inv !== ei || vld !== ev) begin
            errors++;
            $display("FAIL %s: mask=%h inv=%b vld=%b expected mask=%h inv=%b vld=%b",
                     req, mask, inv, vld, em, ei, ev);
        end
    endtask

    task automatic apply(input logic w, input logic [5:0] r, input logic [5:0] s);
        @(negedge clk);
        wide = w; rot = r; size = s; in_vld = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    initial begin
        logic [64:0] exp_v;
        repeat (3) @(negedge clk);
        check("R10", 64'h0, 1'b0, 1'b0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][77], VEC[v][76:71], VEC[v][70:65]);
            check("R1-table", VEC[v][64:1], VEC[v][0], 1'b1); // R1 R2 R3 R4 R5 R6 R7
        end

        // R8: one-cycle latency, valid drops next cycle
        apply(1'b1, 6'd2, 6'd0);
        check("R8", 64'h4000000000000000, 1'b0, 1'b1);
        @(negedge clk);
        check("R8", 64'h4000000000000000, 1'b0, 1'b0);

        // R9: fields change without in_vld, outputs hold
        wide = 1'b0; rot = 6'd0; size = 6'b111111;
        repeat (2) @(negedge clk);
        check("R9", 64'h4000000000000000, 1'b0, 1'b0);

        // R11: single set bit and single clear bit at every position
        for (int k = 0; k < 64; k++) begin
            apply(1'b1, 6'(k), 6'd0);
            check("R11", 64'h1 << ((64 - k) % 64), 1'b0, 1'b1);
            apply(1'b1, 6'(k), 6'd62);
            check("R11", ~(64'h1 << ((127 - k) % 64)), 1'b0, 1'b1);
        end

        // exhaustive sweep against the index model
        for (int e = 0; e < 8192; e++) begin
            apply(e[12], e[11:6], e[5:0]);
            exp_v = ref_model(e[12], e[11:6], e[5:0]);
            check("R7-sweep", exp_v[63:0], exp_v[64], 1'b1);
        end

        // R10: reset mid-run clears outputs
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R10", 64'h0, 1'b0, 1'b0);
        rst = 1'b0;
        done = 1;
    end

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: run did not finish");
            end
            wait (done);
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end
endmodule